// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of sixteen lines. Software reaches it over a simple 32-bit register bus with separate read and write strobes. Each line can be made an input or an output. Output lines drive the pin-output vector from a stored drive value. Input lines are sampled through a two-flop synchronizer. Each input line can latch an interrupt flag on either a rising or a falling transition, selected per line.

A flag is latched only when its line is an input and its mask bit is clear. The interrupt output is a registered level that stays high while any flag is set. Software clears flags by writing ones to the flag register. A pin-gate register hides chosen lines from the sampled-input readback. Offsets outside the map read as zero, and writes to them have no effect.

Top module: `gpx_port`

## Requirements
- R1: After reset, the drive, direction, polarity, mask and pin-gate registers read 0x0000FFFF. The flag register and the sampled-input register read 0. `irq` is 0 and `pin_out` is 0.
- R2: `pin_out[i]` equals drive bit i when direction bit i is 0 (output), and is 0 when direction bit i is 1 (input). A write to the drive or direction register shows on `pin_out` from the clock edge that takes the write.
- R3: A line whose polarity bit is 1 latches its flag on a 0-to-1 transition of its synchronized input. A pin change that is present at clock edge k appears in the flag register, and on `irq`, after edge k+2.
- R4: A line whose polarity bit is 0 latches its flag on a 1-to-0 transition of its synchronized input, with the same latency as R3. Transitions in the other direction latch nothing.
- R5: No flag is latched on a line whose mask bit is 1, or on a line whose direction bit is 0.
- R6: A write to the flag register clears every flag bit written as 1 and leaves the other bits unchanged. A transition detected in the same cycle as the clearing write still sets its flag.
- R7: `irq` is 1 exactly when at least one flag bit is set. It changes at the same clock edge as the flag register.
- R8: Reading the sampled-input register returns the synchronized pin values ANDed with the pin-gate register.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is high, and it holds that value until the next read. Bits 31:16 always read 0.
- R10: A read of an unmapped offset returns 0. A write to an unmapped offset, or to the read-only sampled-input register, changes no register.
- R11: The register offsets are: 0x00 sampled input (read-only), 0x04 drive, 0x08 direction (1 = input), 0x0C polarity (1 = rising), 0x10 mask (1 = masked), 0x14 flags (write 1 to clear), 0x18 pin gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Driven pin outputs |
| irq | output | 1 | Level interrupt |

## Verification
Edge detection is exercised with one mixed polarity word, so that rising-selected and falling-selected lines see the same pin transitions. Each edge kind therefore both fires on its own lines and stays silent on the others. Further pin toggles run on masked lines and on output-direction lines, which shows that gating depends on both the mask and the direction. Flag clears use partial patterns, including a clear issued in the very cycle a new edge is detected, which tests the set-over-clear priority. Direction changes over a fixed drive word, pin-gate readback, and unmapped or read-only accesses complete the patterns.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   // Byte offsets of the register map
   localparam logic [7:0] OFS_SAMPLE = 8'h00;
   localparam logic [7:0] OFS_DRIVE  = 8'h04;
   localparam logic [7:0] OFS_DIR    = 8'h08;
   localparam logic [7:0] OFS_POL    = 8'h0C;
   localparam logic [7:0] OFS_MASK   = 8'h10;
   localparam logic [7:0] OFS_FLAG   = 8'h14;
   localparam logic [7:0] OFS_GATE   = 8'h18;

   typedef enum logic [2:0] {
      SEL_SAMPLE,
      SEL_DRIVE,
      SEL_DIR,
      SEL_POL,
      SEL_MASK,
      SEL_FLAG,
      SEL_GATE,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_edge.sv
module gpx_edge #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] mask,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] flag_q,
   output logic         irq
);
   logic [W-1:0] prev_q;
   logic [W-1:0] hit;
   logic [W-1:0] flag_d;

   for (genvar i = 0; i < W; i++) begin : g_line
      assign hit[i] = pol[i] ? (cur[i] & ~prev_q[i]) : (~cur[i] & prev_q[i]);
   end

   always_comb begin
      flag_d = flag_q & ~(clr_en ? clr_bits : '0);
      flag_d = flag_d | (hit & dir & ~mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag_q <= '0;
         irq    <= 1'b0;
      end else begin
         prev_q <= cur;
         flag_q <= flag_d;
         irq    <= |flag_d;
      end
   end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
#(
   parameter int W      = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [W-1:0]      sample,
   input  logic [W-1:0]      flag_q,
   output logic [W-1:0]      drive_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      pol_q,
   output logic [W-1:0]      mask_q,
   output logic [W-1:0]      gate_q,
   output logic              clr_en,
   output logic [W-1:0]      clr_bits,
   output logic [DATA_W-1:0] rdata
);
   reg_sel_e          sel;
   logic [DATA_W-1:0] rd_word;
   logic [W-1:0]      wbits;

   assign wbits = wdata[W-1:0];

   if (DATA_W > W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:W];
   end

   always_comb begin
      if      (addr == ADDR_W'(OFS_SAMPLE)) sel = SEL_SAMPLE;
      else if (addr == ADDR_W'(OFS_DRIVE))  sel = SEL_DRIVE;
      else if (addr == ADDR_W'(OFS_DIR))    sel = SEL_DIR;
      else if (addr == ADDR_W'(OFS_POL))    sel = SEL_POL;
      else if (addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
      else if (addr == ADDR_W'(OFS_FLAG))   sel = SEL_FLAG;
      else if (addr == ADDR_W'(OFS_GATE))   sel = SEL_GATE;
      else                                  sel = SEL_NONE;
   end

   always_comb begin
      rd_word = '0;
      case (sel)
         SEL_SAMPLE: rd_word[W-1:0] = sample & gate_q;
         SEL_DRIVE:  rd_word[W-1:0] = drive_q;
         SEL_DIR:    rd_word[W-1:0] = dir_q;
         SEL_POL:    rd_word[W-1:0] = pol_q;
         SEL_MASK:   rd_word[W-1:0] = mask_q;
         SEL_FLAG:   rd_word[W-1:0] = flag_q;
         SEL_GATE:   rd_word[W-1:0] = gate_q;
         default:    rd_word = '0;
      endcase
   end

   assign clr_en   = wr && (sel == SEL_FLAG);
   assign clr_bits = wbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= '1;
         dir_q   <= '1;
         pol_q   <= '1;
         mask_q  <= '1;
         gate_q  <= '1;
         rdata   <= '0;
      end else begin
         if (rd) rdata <= rd_word;
         if (wr) begin
            case (sel)
               SEL_DRIVE: drive_q <= wbits;
               SEL_DIR:   dir_q   <= wbits;
               SEL_POL:   pol_q   <= wbits;
               SEL_MASK:  mask_q  <= wbits;
               SEL_GATE:  gate_q  <= wbits;
               default:   ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
   parameter int NUM_LINES   = 16,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic                 irq
);
   localparam int MIN_ADDR_W = 5;

   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("gpx_port: NUM_LINES must lie in 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpx_port: ADDR_W too narrow for the register map");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("gpx_port: SYNC_STAGES must be at least 1");
   end

   logic [NUM_LINES-1:0] sample;
   logic [NUM_LINES-1:0] drive_q, dir_q, pol_q, mask_q, gate_q;
   logic [NUM_LINES-1:0] flag_q, clr_bits;
   logic                 clr_en;

   gpx_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sample)
   );

   gpx_regs #(.W(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .sample(sample), .flag_q(flag_q),
      .drive_q(drive_q), .dir_q(dir_q), .pol_q(pol_q), .mask_q(mask_q),
      .gate_q(gate_q), .clr_en(clr_en), .clr_bits(clr_bits), .rdata(bus_rdata)
   );

   gpx_edge #(.W(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur(sample), .pol(pol_q), .dir(dir_q),
      .mask(mask_q), .clr_en(clr_en), .clr_bits(clr_bits),
      .flag_q(flag_q), .irq(irq)
   );

   assign pin_out = drive_q & ~dir_q;
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk
   import gpx_pkg::*;
#(
   parameter int W      = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [W-1:0]      pin_out,
   input logic [W-1:0]      dir_q,
   input logic [W-1:0]      mask_q,
   input logic [W-1:0]      flag_q
);
   logic armed;
   logic mapped;
   logic flag_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign mapped = bus_addr == ADDR_W'(OFS_SAMPLE) || bus_addr == ADDR_W'(OFS_DRIVE) ||
                   bus_addr == ADDR_W'(OFS_DIR)    || bus_addr == ADDR_W'(OFS_POL)   ||
                   bus_addr == ADDR_W'(OFS_MASK)   || bus_addr == ADDR_W'(OFS_FLAG)  ||
                   bus_addr == ADDR_W'(OFS_GATE);
   assign flag_wr = bus_wr && bus_addr == ADDR_W'(OFS_FLAG);

   // R2
   input_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & dir_q) == '0);

   // R7
   irq_tracks_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (|flag_q));

   // R5
   gated_lines_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((flag_q & ~$past(flag_q) & $past(mask_q | ~dir_q)) == '0));

   // R6
   flags_fall_only_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(flag_wr)) |-> (($past(flag_q) & ~flag_q) == '0));

   // R10
   unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(bus_rd && !mapped)) |-> bus_rdata == '0);

   // R9
   rdata_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(bus_rd)) |-> $stable(bus_rdata));
endmodule

bind gpx_port gpx_port_chk #(.W(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_rdata(bus_rdata), .irq(irq), .pin_out(pin_out), .dir_q(dir_q),
   .mask_q(mask_q), .flag_q(flag_q)
);

// File: tb/sim_gpx_port.sv
`timescale 1ns/1ps
module sim_gpx_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit live = 0;

   always #10 clk = ~clk;

   gpx_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .irq(irq)
   );

   // behavioural reference
   logic [15:0] m_s1, m_s2, m_prev, m_drive, m_dir, m_pol, m_mask, m_flag, m_gate;
   logic [31:0] m_rdata;

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return {16'h0, m_s2 & m_gate};
         8'h04: return {16'h0, m_drive};
         8'h08: return {16'h0, m_dir};
         8'h0C: return {16'h0, m_pol};
         8'h10: return {16'h0, m_mask};
         8'h14: return {16'h0, m_flag};
         8'h18: return {16'h0, m_gate};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_flag = 0; m_rdata = 0;
         m_drive = 16'hFFFF; m_dir = 16'hFFFF; m_pol = 16'hFFFF;
         m_mask = 16'hFFFF; m_gate = 16'hFFFF;
      end else begin
         logic [15:0] rise, fall, hit, clr, nflag;
         rise = m_s2 & ~m_prev;
         fall = ~m_s2 & m_prev;
         hit = (rise & m_pol) | (fall & ~m_pol);
         clr = (bus_wr && bus_addr == 8'h14) ? bus_wdata[15:0] : 16'h0;
         nflag = (m_flag & ~clr) | (hit & m_dir & ~m_mask);
         if (bus_rd) m_rdata = m_read(bus_addr);
         if (bus_wr) begin
            case (bus_addr)
               8'h04: m_drive = bus_wdata[15:0];
               8'h08: m_dir   = bus_wdata[15:0];
               8'h0C: m_pol   = bus_wdata[15:0];
               8'h10: m_mask  = bus_wdata[15:0];
               8'h18: m_gate  = bus_wdata[15:0];
               default: ;
            endcase
         end
         m_flag = nflag;
         m_prev = m_s2;
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (live) begin
         chk("R2 pin_out", {16'h0, pin_out}, {16'h0, m_drive & ~m_dir});
         chk("R7 irq", {31'h0, irq}, {31'h0, |m_flag});
      end
   end

   // tasks start just after a falling edge
   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, input string tag, input logic [31:0] exp);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(tag, bus_rdata, exp);
      chk({tag, " model"}, bus_rdata, m_rdata);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      live = 1;
      // R1 reset values
      chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      rd_reg(8'h00, "R1 sample", 32'h0);
      rd_reg(8'h04, "R1 drive", 32'h0000FFFF);
      rd_reg(8'h08, "R1 dir", 32'h0000FFFF);
      rd_reg(8'h0C, "R1 pol", 32'h0000FFFF);
      rd_reg(8'h10, "R1 mask", 32'h0000FFFF);
      rd_reg(8'h14, "R1 flag", 32'h0);
      rd_reg(8'h18, "R1 gate", 32'h0000FFFF);

      // R2 direction over a stored drive word
      wr_reg(8'h04, 32'hFFFFA5A5);
      wr_reg(8'h08, 32'h0000FF00);
      chk("R2 out low byte", {16'h0, pin_out}, 32'h000000A5);
      wr_reg(8'h08, 32'h00000F0F);
      chk("R2 out after dir", {16'h0, pin_out}, 32'h0000A0A0);
      rd_reg(8'h04, "R11 R9 drive upper zero", 32'h0000A5A5);

      // R3 R4 mixed polarity
      wr_reg(8'h08, 32'h0000FFFF);
      wr_reg(8'h0C, 32'h000000FF);
      wr_reg(8'h10, 32'h00000000);
      pin_in = 16'h000F;
      idle(3);
      rd_reg(8'h14, "R3 rising flags", 32'h0000000F);
      chk("R7 irq high", {31'h0, irq}, 32'h1);
      pin_in = 16'h0F0F;
      idle(3);
      rd_reg(8'h14, "R4 rise ignored on falling lines", 32'h0000000F);
      pin_in = 16'h000F;
      idle(3);
      rd_reg(8'h14, "R4 falling flags", 32'h00000F0F);
      pin_in = 16'h0000;
      idle(3);
      rd_reg(8'h14, "R3 fall ignored on rising lines", 32'h00000F0F);

      // R6 partial clear, R7 irq drop
      wr_reg(8'h14, 32'h00000105);
      rd_reg(8'h14, "R6 partial clear", 32'h00000E0A);
      wr_reg(8'h14, 32'hFFFFFFFF);
      chk("R7 irq low", {31'h0, irq}, 32'h0);
      rd_reg(8'h14, "R6 all clear", 32'h0);

      // R5 masked lines and output lines
      wr_reg(8'h10, 32'h000000F0);
      pin_in = 16'h00F0;
      idle(3);
      rd_reg(8'h14, "R5 masked no flag", 32'h0);
      wr_reg(8'h10, 32'h00000000);
      wr_reg(8'h08, 32'h0000EFFF);
      pin_in = 16'h10F0;
      idle(3);
      pin_in = 16'h00F0;
      idle(3);
      rd_reg(8'h14, "R5 output line no flag", 32'h0);
      chk("R5 irq stays low", {31'h0, irq}, 32'h0);
      wr_reg(8'h08, 32'h0000FFFF);

      // R6 clear in the same cycle as a detected edge
      pin_in = 16'h00F1;
      @(negedge clk);
      @(negedge clk);
      wr_reg(8'h14, 32'h00000001);
      rd_reg(8'h14, "R6 set wins over clear", 32'h00000001);
      wr_reg(8'h14, 32'h00000001);

      // R8 gated readback
      pin_in = 16'h5A3C;
      idle(3);
      rd_reg(8'h00, "R8 sample all gated in", 32'h00005A3C);
      wr_reg(8'h18, 32'h000000FF);
      rd_reg(8'h00, "R8 sample gated", 32'h0000003C);

      // R10 unmapped and read-only accesses
      rd_reg(8'h1C, "R10 unmapped read", 32'h0);
      rd_reg(8'h40, "R10 far unmapped read", 32'h0);
      wr_reg(8'h1C, 32'h00000000);
      wr_reg(8'h00, 32'h00000000);
      wr_reg(8'h02, 32'h00000000);
      rd_reg(8'h04, "R10 drive kept", 32'h0000A5A5);
      rd_reg(8'h18, "R10 gate kept", 32'h000000FF);
      rd_reg(8'h00, "R10 sample kept", 32'h0000003C);
      idle(2);
      chk("R9 rdata held", bus_rdata, 32'h0000003C);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule